// File: doc/BRIEF.md
# Split-Storage Four-Sample Pixel Buffer

This block holds a 4x multisampled depth or colour buffer in two tiers. Every pixel keeps its first sample, the base, in a fast on-chip register store. A three-bit on-chip mask records which of samples 1, 2 and 3 differ from the base. Only the differing samples are kept in a slower external memory, reached through a request/acknowledge port. Most pixels are interior pixels, where all four samples agree. Those pixels never touch the external memory. Edge pixels pay one external transfer for each sample that differs.

A client writes or reads a whole four-sample pixel at a time through a valid/ready port. A write compares samples 1 to 3 against the base. It updates the mask and the base, then stores each differing sample in its external slot. A read rebuilds the full pixel. An unflagged sample is filled in with the base. A flagged sample is fetched from external memory. The rebuilt pixel is returned on a one-cycle valid pulse.

Top module: `msaa_split_store`

## Requirements
- R1: After reset, req_ready is 1, rd_valid and ext_req are 0, every mask is clear and every base is zero. Each pixel therefore reads back as four zero samples with no external access.
- R2: A read of a pixel whose mask is clear raises rd_valid in the cycle right after acceptance. Its rd_data holds four copies of the base, and no external access is made.
- R3: On a write, sample k (1..3) sets its mask bit exactly when it differs from sample 0. Each differing sample is written to external address pixel*3+(k-1), in ascending k order, one transfer per differing sample.
- R4: A write whose four samples are all equal completes with no external access, and req_ready stays 1.
- R5: rd_data carries sample k at bits [k*SAMPLE_W +: SAMPLE_W]. An unflagged sample returns the base. A flagged sample returns the external word at pixel*3+(k-1), and exactly one external read is made for each flagged sample.
- R6: ext_req, ext_we, ext_addr and ext_wdata stay stable from the rise of ext_req until the cycle in which ext_ack is 1. The acknowledge may come after any number of stall cycles.
- R7: req_ready is 0 from the cycle after a request that needs external transfers is accepted, until the cycle after its last acknowledge. External traffic starts only right after an acceptance.
- R8: Rewriting a pixel with equal samples clears its mask. Later reads return the base for every sample, and stale external contents are ignored.
- R9: rd_valid is a one-cycle pulse. A new request can be accepted in the same cycle that rd_valid is high, and that request's own result follows in the next cycle when no external fetch is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = pixel write, 0 = pixel read |
| req_pixel | input | PIX_W | Pixel index |
| req_data | input | 4*SAMPLE_W | Four write samples, sample k at [k*SAMPLE_W +: SAMPLE_W] |
| rd_valid | output | 1 | One-cycle pulse: rebuilt pixel on rd_data |
| rd_data | output | 4*SAMPLE_W | Rebuilt four-sample pixel |
| ext_req | output | 1 | External transfer request |
| ext_we | output | 1 | External transfer is a write |
| ext_addr | output | EXT_AW | External sample slot address |
| ext_wdata | output | SAMPLE_W | External write sample |
| ext_ack | input | 1 | External transfer completes this cycle |
| ext_rdata | input | SAMPLE_W | External read sample, valid with ext_ack |

## Verification
Two events can fall into the same clock cycle. A read of a uniform pixel delivers its result, and in that same cycle a fresh request is accepted. In a separate case, a uniform write updates the mask and the base while the next request reads that same pixel one cycle later. The bench provokes the first case by driving a second read in the very cycle where rd_valid is high. It then judges both rd_valid pulses, in consecutive cycles, against the full-resolution reference pixels. The second case arises naturally in the sweep, because every uniform write is followed at once by a read of the same pixel. That read must already see the new base and the cleared mask.

// File: rtl/msaa_pkg.sv
package msaa_pkg;
   localparam int NSAMP = 4;

   typedef enum logic {ST_IDLE, ST_XFER} seq_st_t;

   // lowest pending extra-sample index (0..2 maps to samples 1..3)
   function automatic logic [1:0] first_set(input logic [2:0] m);
      if (m[0])      return 2'd0;
      else if (m[1]) return 2'd1;
      else           return 2'd2;
   endfunction
endpackage

// File: rtl/msaa_sample_cmp.sv
module msaa_sample_cmp #(
   parameter int SAMPLE_W = 32
) (
   input  logic [4*SAMPLE_W-1:0] pix_data,
   output logic [2:0]            diff
);
   for (genvar k = 1; k < msaa_pkg::NSAMP; k++) begin : g_cmp
      assign diff[k-1] = pix_data[k*SAMPLE_W +: SAMPLE_W] != pix_data[0 +: SAMPLE_W];
   end
endmodule

// File: rtl/msaa_base_store.sv
module msaa_base_store #(
   parameter int SAMPLE_W   = 32,
   parameter int NUM_PIXELS = 16,
   localparam int PIX_W     = $clog2(NUM_PIXELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [PIX_W-1:0]    wr_pix,
   input  logic [SAMPLE_W-1:0] wr_base,
   input  logic [2:0]          wr_mask,
   input  logic [PIX_W-1:0]    rd_pix,
   output logic [SAMPLE_W-1:0] rd_base,
   output logic [2:0]          rd_mask
);
   logic [SAMPLE_W-1:0] base_q [NUM_PIXELS];
   logic [2:0]          mask_q [NUM_PIXELS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PIXELS; i++) begin
            base_q[i] <= '0;
            mask_q[i] <= '0;
         end
      end else if (wr_en) begin
         base_q[wr_pix] <= wr_base;
         mask_q[wr_pix] <= wr_mask;
      end
   end

   assign rd_base = base_q[rd_pix];
   assign rd_mask = mask_q[rd_pix];
endmodule

// File: rtl/msaa_split_store.sv
module msaa_split_store #(
   parameter int SAMPLE_W   = 32,
   parameter int NUM_PIXELS = 16,
   localparam int PIX_W     = $clog2(NUM_PIXELS),
   localparam int EXT_AW    = $clog2(NUM_PIXELS * 3)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [PIX_W-1:0]      req_pixel,
   input  logic [4*SAMPLE_W-1:0] req_data,
   output logic                  rd_valid,
   output logic [4*SAMPLE_W-1:0] rd_data,
   output logic                  ext_req,
   output logic                  ext_we,
   output logic [EXT_AW-1:0]     ext_addr,
   output logic [SAMPLE_W-1:0]   ext_wdata,
   input  logic                  ext_ack,
   input  logic [SAMPLE_W-1:0]   ext_rdata
);
   import msaa_pkg::*;

   if (NUM_PIXELS < 2) begin : g_bad_pix
      $error("NUM_PIXELS must be at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_w
      $error("SAMPLE_W must be at least 1");
   end

   seq_st_t                st_q;
   logic                   op_wr_q;
   logic [PIX_W-1:0]       pix_q;
   logic [2:0]             pend_q;
   logic [4*SAMPLE_W-1:0]  wdat_q;
   logic [4*SAMPLE_W-1:0]  res_q;
   logic                   rd_valid_q;

   logic [2:0]             wr_diff;
   logic [SAMPLE_W-1:0]    st_base;
   logic [2:0]             st_mask;
   logic                   accept;
   logic [1:0]             cur;
   logic [2:0]             pend_nxt;

   msaa_sample_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
      .pix_data (req_data),
      .diff     (wr_diff)
   );

   msaa_base_store #(.SAMPLE_W(SAMPLE_W), .NUM_PIXELS(NUM_PIXELS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept && req_write),
      .wr_pix  (req_pixel),
      .wr_base (req_data[0 +: SAMPLE_W]),
      .wr_mask (wr_diff),
      .rd_pix  (req_pixel),
      .rd_base (st_base),
      .rd_mask (st_mask)
   );

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign cur       = first_set(pend_q);
   assign pend_nxt  = pend_q & ~(3'b001 << cur);

   assign ext_req   = (st_q == ST_XFER);
   assign ext_we    = op_wr_q;
   assign ext_addr  = EXT_AW'(pix_q) * EXT_AW'(3) + EXT_AW'(cur);
   assign ext_wdata = wdat_q[SAMPLE_W*(int'(cur)+1) +: SAMPLE_W];
   assign rd_valid  = rd_valid_q;
   assign rd_data   = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         op_wr_q    <= 1'b0;
         pix_q      <= '0;
         pend_q     <= '0;
         wdat_q     <= '0;
         res_q      <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= 1'b0;
         if (accept) begin
            pix_q   <= req_pixel;
            op_wr_q <= req_write;
            wdat_q  <= req_data;
            if (req_write) begin
               pend_q <= wr_diff;
               st_q   <= (wr_diff != 3'b000) ? ST_XFER : ST_IDLE;
            end else begin
               pend_q <= st_mask;
               res_q  <= {4{st_base}};
               if (st_mask == 3'b000) rd_valid_q <= 1'b1;
               else                   st_q       <= ST_XFER;
            end
         end else if (ext_req && ext_ack) begin
            if (!op_wr_q) res_q[SAMPLE_W*(int'(cur)+1) +: SAMPLE_W] <= ext_rdata;
            pend_q <= pend_nxt;
            if (pend_nxt == 3'b000) begin
               st_q <= ST_IDLE;
               if (!op_wr_q) rd_valid_q <= 1'b1;
            end
         end
      end
   end

   // R6: outstanding external transfer holds its command until acknowledged
   a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata)));

   // R4: uniform write causes no external traffic and keeps the port open
   a_r4_uniform_write_local: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_write && wr_diff == 3'b000) |=> (!ext_req && req_ready));

   // R2: read of an unflagged pixel answers next cycle without external access
   a_r2_clean_read_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && st_mask == 3'b000) |=> (rd_valid && !ext_req));

   // R7: external traffic begins only right after a request was accepted
   a_r7_xfer_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_req) |-> $past(req_valid && req_ready));

   // R5: last external read acknowledge delivers the rebuilt pixel next cycle
   a_r5_last_fetch_done: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && ext_ack && !ext_we && $countones(pend_q) == 1) |=> (rd_valid && req_ready));
endmodule

// File: tb/sim_msaa_split_store.sv
`timescale 1ns/1ps
module sim_msaa_split_store;
   localparam int SW    = 32;
   localparam int NPIX  = 16;
   localparam int PW    = $clog2(NPIX);
   localparam int AW    = $clog2(NPIX * 3);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [PW-1:0] req_pixel = '0;
   logic [4*SW-1:0] req_data = '0;
   logic req_ready, rd_valid, ext_req, ext_we;
   logic [4*SW-1:0] rd_data;
   logic [AW-1:0] ext_addr;
   logic [SW-1:0] ext_wdata;
   logic ext_ack = 1'b0;
   logic [SW-1:0] ext_rdata = '0;

   int tests = 0, fails = 0, nacc = 0, sseq = 0, wcnt = 0;
   logic [SW-1:0]   xmem [NPIX*3];
   logic [4*SW-1:0] refp [NPIX];

   always #5 clk = ~clk;

   msaa_split_store #(.SAMPLE_W(SW), .NUM_PIXELS(NPIX)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_pixel(req_pixel), .req_data(req_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .ext_req(ext_req), .ext_we(ext_we),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata));

   // external memory model: variable stall, ack at negedge, commit at posedge
   always @(negedge clk) begin
      if (!rst_n) begin
         ext_ack = 1'b0; wcnt = 0;
      end else if (ext_req && !ext_ack && wcnt == 0) begin
         ext_ack   = 1'b1;
         ext_rdata = xmem[ext_addr];
         sseq      = sseq + 1;
         wcnt      = (sseq * 7) % 4;
      end else begin
         ext_ack = 1'b0;
         if (ext_req && wcnt > 0) wcnt = wcnt - 1;
      end
   end

   always @(posedge clk) begin
      if (rst_n && ext_req && ext_ack) begin
         nacc <= nacc + 1;
         if (ext_we) xmem[ext_addr] <= ext_wdata;
      end
   end

   task automatic chk(input string req, input logic [4*SW-1:0] act, input logic [4*SW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] mask_of(input logic [4*SW-1:0] d);
      logic [2:0] m;
      for (int k = 1; k < 4; k++) m[k-1] = d[k*SW +: SW] != d[0 +: SW];
      return m;
   endfunction

   // assumes caller is at a negedge; returns at first negedge after acceptance
   task automatic issue(input bit wr, input int p, input logic [4*SW-1:0] d);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_pixel = PW'(p); req_data = d;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_write(input int p, input logic [4*SW-1:0] d);
      int n0;
      logic [2:0] m;
      m  = mask_of(d);
      n0 = nacc;
      issue(1'b1, p, d);
      if (m != 3'b000) chk("R7 busy after edge write", {127'b0, req_ready}, '0);
      else             chk("R4 ready kept on uniform write", {126'b0, req_ready, ext_req}, {126'b0, 2'b10});
      while (!req_ready) @(negedge clk);
      chk("R3/R4 external write count", 128'(nacc - n0), 128'($countones(m)));
      for (int k = 1; k < 4; k++)
         if (m[k-1]) chk("R3 external slot content", 128'(xmem[p*3+k-1]), 128'(d[k*SW +: SW]));
      refp[p] = d;
   endtask

   task automatic do_read(input int p);
      int n0, lat;
      logic [2:0] m;
      m   = mask_of(refp[p]);
      n0  = nacc;
      lat = 0;
      issue(1'b0, p, '0);
      while (!rd_valid) begin @(negedge clk); lat++; end
      chk("R5/R8 rebuilt pixel", rd_data, refp[p]);
      chk("R5 external read count", 128'(nacc - n0), 128'($countones(m)));
      if (m == 3'b000) chk("R2 clean read latency", 128'(lat), 128'(0));
   endtask

   function automatic logic [4*SW-1:0] mk(input int p, input int m, input int salt);
      logic [SW-1:0] b;
      logic [4*SW-1:0] d;
      b = SW'(32'hA000_0000 + p*256 + m*16 + salt);
      d[0 +: SW] = b;
      for (int k = 1; k < 4; k++)
         d[k*SW +: SW] = m[k-1] ? (b ^ SW'(32'h0F00_0000 + k)) : b;
      return d;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NPIX*3; i++) xmem[i] = SW'(32'hDEAD_0000 + i);
      for (int i = 0; i < NPIX; i++) refp[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1 reset outputs", {125'b0, req_ready, rd_valid, ext_req}, {125'b0, 3'b100});
      for (int p = 0; p < NPIX; p++) do_read(p);
      chk("R1 no external traffic after reset reads", 128'(nacc), 128'(0));

      // sweep every pixel through all mask patterns, ending uniform (R8)
      for (int p = 0; p < NPIX; p++)
         for (int m = 7; m >= 0; m--) begin
            do_write(p, mk(p, m, 1));
            do_read(p);
         end

      // R8: edge pixel rewritten as uniform ignores stale external data
      do_write(9, mk(9, 7, 3));
      do_write(9, mk(9, 0, 5));
      do_read(9);
      chk("R8 uniform rewrite reads base", rd_data, {4{mk(9, 0, 5)[0 +: SW]}});

      // R9: second read accepted in the cycle the first result is valid
      issue(1'b0, 3, '0);
      chk("R9 first pulse", {127'b0, rd_valid}, 128'(1));
      chk("R9 first data", rd_data, refp[3]);
      chk("R9 ready during pulse", {127'b0, req_ready}, 128'(1));
      issue(1'b0, 4, '0);
      chk("R9 second pulse back to back", {127'b0, rd_valid}, 128'(1));
      chk("R9 second data", rd_data, refp[4]);
      @(negedge clk);
      chk("R9 pulse ends", {127'b0, rd_valid}, 128'(0));

      // mixed edge pixels read in a burst
      for (int p = 0; p < NPIX; p++) do_write(p, mk(p, (p % 7) + 1, 7));
      for (int p = NPIX - 1; p >= 0; p--) do_read(p);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule